// File: doc/BRIEF.md
# ADC Serial Master

This block is a master-only synchronous serial controller that talks to an external analog-to-digital converter. The host sets a framing mode, a clock polarity and a command word, then pulses `start`. The controller pulls its active-low select line low, drives the serial clock, shifts the command out most significant bit first, and shifts the converter's answer in. When the exchange completes it releases the select line, pulses `done` for one cycle and holds the received word on `rdata` until the next exchange completes.

Two framings are supported. In full-duplex framing, sixteen clocks carry the whole 16-bit command out while sixteen result bits come in. In three-wire framing, eight clocks carry the low command byte, one clock is a turnaround with the output held low and the input ignored, and sixteen further clocks bring in the result. A separate, free-running sample clock for the converter is divided from the system clock by its own programmable count and runs with no dependence on transfers.

The controller steps through four states. IDLE waits for `start`; IDLE to LEAD happens when `start` is seen. LEAD holds select low with the clock idle for one half bit period; LEAD to SHIFT happens at the end of that half period and makes the first clock edge. SHIFT toggles the clock once per half bit period; SHIFT to TRAIL happens on the last trailing edge. TRAIL holds select low for one more half bit period; TRAIL to IDLE releases select, latches the result and pulses `done`. A half bit period is `HALF_CYC` system clocks, so with the default of 4 and a 1.024 MHz system clock the bit rate is 128 kbit/s.

Top module: `adcif_master`

## Requirements
- R1: While reset is held low, cs_n is 1, sclk, mosi, busy, done, smp_clk are 0 and rdata is 0.
- R2: A start seen in IDLE makes busy 1 and cs_n 0 from the next cycle; cs_n stays low for HALF_CYC cycles with sclk at its idle level before the first clock edge.
- R3: With mode_mw = 0 a transfer has 16 clocks; mosi carries cmd[15] down to cmd[0], one bit per clock, each bit changing only just after a trailing edge; miso is sampled on every leading edge, the first sample landing in rdata[15].
- R4: With mode_mw = 1 a transfer has 25 clocks; mosi carries cmd[7] down to cmd[0] on clocks 1 to 8 and is 0 from clock 9 on; the miso value at clock 9 is discarded and the values at clocks 10 to 25 form rdata, the first in rdata[15].
- R5: sclk rests at the value of cpol while idle (one cycle after cpol changes) and the leading edge moves it to the opposite level; the polarity is captured when a transfer is accepted and a change of cpol during the transfer has no effect on sclk until it returns to IDLE.
- R6: cs_n returns to 1 HALF_CYC cycles after the last trailing edge; done is 1 for exactly that first cycle with cs_n high, and rdata changes only in that cycle.
- R7: A start while busy is ignored: the running transfer continues unchanged and no second transfer follows; a start held into the first idle cycle begins a new transfer.
- R8: smp_clk toggles once every smp_div + 1 system clocks, regardless of transfer activity.
- R9: During a transfer each sclk level lasts exactly HALF_CYC system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a transfer |
| mode_mw | input | 1 | 0: 16-bit full-duplex framing, 1: byte command, turnaround clock, 16-bit result |
| cpol | input | 1 | Idle level of sclk |
| cmd | input | DATA_W | Command word to send |
| smp_div | input | SMP_W | Sample-clock half period minus one, in system clocks |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the converter |
| cs_n | output | 1 | Active-low converter select |
| smp_clk | output | 1 | Free-running converter sample clock |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rdata | output | DATA_W | Last received word |

## Verification
Transfers are run in both framings and both polarities with command words whose bit patterns differ (alternating, sparse, single end bits) and with converter response streams that differ between the turnaround slot and the payload, so a wrong sampling edge, a missing turnaround clock or an off-by-one bit position shows up as a different `rdata` or `mosi` sequence. A polarity flip and start pulses are injected mid-transfer to tell a latched polarity and an ignored start from live ones, and a start held across the end of a transfer separates an accepted restart from a dropped one. The sample-clock divider is changed between values, including zero, while transfers run, which distinguishes an independent divider from one tied to the serial engine.

// File: rtl/adcif_pkg.sv
package adcif_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TRAIL = 2'd3
    } adcif_state_e;

endpackage

// File: rtl/adcif_halftick.sv
module adcif_halftick #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] TOP = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= (cnt == TOP) ? '0 : cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == TOP);

    assert_cnt_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TOP);

    generate
        if (HALF_CYC > 1) begin : g_gap
            assert_tick_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/adcif_smpclk.sv
module adcif_smpclk #(
    parameter int SMP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SMP_W-1:0] div,
    output logic             smp_clk
);
    logic [SMP_W-1:0] cnt;
    logic             level;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            level <= 1'b0;
        end else if (cnt >= div) begin
            cnt   <= '0;
            level <= ~level;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign smp_clk = level;

    assert_smp_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(smp_clk) |-> (cnt == '0));

endmodule

// File: rtl/adcif_shifter.sv
module adcif_shifter #(
    parameter int CMD_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_mw,
    input  logic [DATA_W-1:0] load_word,
    input  logic              tx_shift,
    input  logic              rx_shift,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_word
);
    localparam int PAD = DATA_W - CMD_W;

    logic [DATA_W-1:0] tx_sr;
    logic [DATA_W-1:0] rx_sr;
    logic [DATA_W-1:0] first_word;

    assign first_word = load_mw ? {load_word[CMD_W-1:0], {PAD{1'b0}}} : load_word;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '0;
            rx_sr <= '0;
        end else if (load) begin
            tx_sr <= first_word;
            rx_sr <= '0;
        end else begin
            if (tx_shift) begin
                tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
            end
            if (rx_shift) begin
                rx_sr <= {rx_sr[DATA_W-2:0], miso};
            end
        end
    end

    assign mosi    = tx_sr[DATA_W-1];
    assign rx_word = rx_sr;

    assert_edges_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_shift && rx_shift));

endmodule

// File: rtl/adcif_master.sv
module adcif_master
    import adcif_pkg::*;
#(
    parameter int HALF_CYC = 4,
    parameter int CMD_W    = 8,
    parameter int DATA_W   = 16,
    parameter int SMP_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode_mw,
    input  logic              cpol,
    input  logic [DATA_W-1:0] cmd,
    input  logic [SMP_W-1:0]  smp_div,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n,
    output logic              smp_clk,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    localparam int SPI_CLKS = DATA_W;
    localparam int MW_CLKS  = CMD_W + 1 + DATA_W;
    localparam int EDGE_W   = $clog2(2 * MW_CLKS + 1);
    localparam logic [EDGE_W-1:0] SPI_LAST   = EDGE_W'(2 * SPI_CLKS - 1);
    localparam logic [EDGE_W-1:0] MW_LAST    = EDGE_W'(2 * MW_CLKS - 1);
    localparam logic [EDGE_W-2:0] MW_GAP_BIT = (EDGE_W - 1)'(CMD_W);

    adcif_state_e      state;
    adcif_state_e      state_nx;
    logic [EDGE_W-1:0] edge_cnt;
    logic [EDGE_W-2:0] bit_idx;
    logic              act;
    logic              cpol_q;
    logic              mw_q;
    logic              done_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rx_word;
    logic              tick;
    logic              running;
    logic              accept;
    logic              last_edge;
    logic              lead_edge;
    logic              trail_edge;
    logic              rx_en;

    assign running    = (state != ST_IDLE);
    assign accept     = (state == ST_IDLE) && start;
    assign bit_idx    = edge_cnt[EDGE_W-1:1];
    assign last_edge  = (edge_cnt == (mw_q ? MW_LAST : SPI_LAST));
    assign lead_edge  = tick && ((state == ST_LEAD) || ((state == ST_SHIFT) && !act));
    assign trail_edge = tick && (state == ST_SHIFT) && act;
    assign rx_en      = lead_edge && (!mw_q || (bit_idx > MW_GAP_BIT));

    adcif_halftick #(
        .HALF_CYC(HALF_CYC)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .run   (running),
        .tick  (tick)
    );

    adcif_shifter #(
        .CMD_W (CMD_W),
        .DATA_W(DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_mw  (mode_mw),
        .load_word(cmd),
        .tx_shift (trail_edge),
        .rx_shift (rx_en),
        .miso     (miso),
        .mosi     (mosi),
        .rx_word  (rx_word)
    );

    adcif_smpclk #(
        .SMP_W(SMP_W)
    ) u_smp (
        .clk    (clk),
        .rst_n  (rst_n),
        .div    (smp_div),
        .smp_clk(smp_clk)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start)             state_nx = ST_LEAD;
            ST_LEAD:  if (tick)              state_nx = ST_SHIFT;
            ST_SHIFT: if (tick && last_edge) state_nx = ST_TRAIL;
            ST_TRAIL: if (tick)              state_nx = ST_IDLE;
            default:                         state_nx = ST_IDLE;
        endcase
    end

    // Per-state registered outputs and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_cnt <= '0;
            act      <= 1'b0;
            cpol_q   <= 1'b0;
            mw_q     <= 1'b0;
            done_q   <= 1'b0;
            rdata_q  <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    cpol_q <= cpol;
                    act    <= 1'b0;
                    if (start) begin
                        mw_q     <= mode_mw;
                        edge_cnt <= '0;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        act      <= 1'b1;
                        edge_cnt <= EDGE_W'(1);
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        act      <= ~act;
                        edge_cnt <= edge_cnt + 1'b1;
                    end
                end
                ST_TRAIL: begin
                    if (tick) begin
                        done_q  <= 1'b1;
                        rdata_q <= rx_word;
                    end
                end
                default: ;
            endcase
        end
    end

    assign sclk  = cpol_q ^ act;
    assign cs_n  = ~running;
    assign busy  = running;
    assign done  = done_q;
    assign rdata = rdata_q;

    assert_lead_clock_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEAD) |-> (sclk == cpol_q));

    assert_edge_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (edge_cnt <= MW_LAST + 1'b1));

    assert_gap_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SHIFT) && mw_q && (bit_idx >= MW_GAP_BIT)) |-> !mosi);

    assert_polarity_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cpol_q));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_at_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !$past(cs_n)));

    assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rdata));

    assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ((state != ST_LEAD) || ($past(state) == ST_LEAD)));

endmodule

// File: tb/adcif_master_test.sv
module adcif_master_test;
    localparam int CLK_PERIOD = 10;
    localparam int H    = 4;
    localparam int CMDW = 8;
    localparam int DW   = 16;
    localparam int SMPW = 8;
    localparam int NSPI = DW;
    localparam int NMW  = CMDW + 1 + DW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            mode_mw = 1'b0;
    logic            cpol = 1'b0;
    logic [DW-1:0]   cmd = '0;
    logic [SMPW-1:0] smp_div = 8'd2;
    logic            miso = 1'b0;
    logic            sclk, mosi, cs_n, smp_clk, busy, done;
    logic [DW-1:0]   rdata;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adcif_master #(
        .HALF_CYC(H), .CMD_W(CMDW), .DATA_W(DW), .SMP_W(SMPW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_mw(mode_mw), .cpol(cpol),
        .cmd(cmd), .smp_div(smp_div), .miso(miso), .sclk(sclk), .mosi(mosi),
        .cs_n(cs_n), .smp_clk(smp_clk), .busy(busy), .done(done), .rdata(rdata)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] actual, input logic [31:0] expected);
        checks++;
        if (actual !== expected) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
        end
    endtask

    // Converter stream: bit k of the transfer is stream[NMW-1-k]
    logic [NMW-1:0] stream = '0;

    // Converter model: presents bit k after k leading edges
    int   trans = 0;
    logic sclk_prev = 1'b0;
    always @(negedge clk) begin
        int k;
        if (cs_n !== 1'b0) trans = 0;
        else if (sclk !== sclk_prev) trans++;
        sclk_prev = sclk;
        k = (trans + 1) / 2;
        miso = (k < NMW) ? stream[NMW-1-k] : 1'b0;
    end

    // Behavioural reference model
    logic           m_busy = 0, m_mw = 0, m_cpol = 0, m_done = 0, m_sc = 0;
    int             m_t = 0, m_sc_cnt = 0;
    logic [DW-1:0]  m_cmd = '0, m_rdata = '0;
    logic [NMW-1:0] m_cap = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_t = 0; m_mw = 0; m_cpol = 0; m_done = 0;
            m_rdata = '0; m_cmd = '0; m_sc = 0; m_sc_cnt = 0;
        end else begin
            if (m_sc_cnt >= int'(smp_div)) begin
                m_sc = ~m_sc; m_sc_cnt = 0;
            end else begin
                m_sc_cnt++;
            end
            if (!m_busy) begin
                m_done = 0;
                m_cpol = cpol;
                if (start) begin
                    m_busy = 1; m_t = 1; m_mw = mode_mw; m_cmd = cmd; m_cap = stream;
                end
            end else if (m_t == (2 * (m_mw ? NMW : NSPI) + 1) * H) begin
                m_busy = 0; m_t = 0; m_done = 1;
                m_rdata = m_mw ? m_cap[DW-1:0] : m_cap[NMW-1:NMW-DW];
            end else begin
                m_t++;
            end
        end
    end

    // Compare on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            int   n, p, bi;
            logic e_act, e_mosi;
            string tag;
            n = m_mw ? NMW : NSPI;
            p = m_busy ? (m_t - 1) / H : 0;
            bi = p / 2;
            e_act = m_busy && (p >= 1) && (p <= 2 * n - 1) && (p % 2 == 1);
            if (!m_busy) e_mosi = 1'b0;
            else if (m_mw) e_mosi = (bi < CMDW) ? m_cmd[CMDW-1-bi] : 1'b0;
            else e_mosi = (bi < DW) ? m_cmd[DW-1-bi] : 1'b0;
            tag = m_mw ? "R4" : "R3";
            chk("R2", "cs_n", cs_n, !m_busy);
            chk(m_busy ? "R9" : "R5", "sclk", sclk, m_cpol ^ e_act);
            chk(tag, "mosi", mosi, e_mosi);
            chk("R7", "busy", busy, m_busy);
            chk("R6", "done", done, m_done);
            chk(tag, "rdata", rdata, m_rdata);
            chk("R8", "smp_clk", smp_clk, m_sc);
        end
    end

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic xfer(input logic mw, input logic pol, input logic [DW-1:0] c,
                        input logic [NMW-1:0] s);
        logic [DW-1:0] want;
        want = mw ? s[DW-1:0] : s[NMW-1:NMW-DW];
        @(negedge clk);
        mode_mw = mw; cpol = pol; cmd = c; stream = s;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2", "busy after start", busy, 1);
        chk("R2", "cs_n after start", cs_n, 0);
        wait_idle();
        chk(mw ? "R4" : "R3", "received word", rdata, want);
        chk("R6", "done at release", done, 1);
        @(negedge clk);
        chk("R6", "done cleared", done, 0);
        chk("R6", "rdata kept", rdata, want);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "cs_n in reset", cs_n, 1);
        chk("R1", "sclk in reset", sclk, 0);
        chk("R1", "mosi in reset", mosi, 0);
        chk("R1", "busy in reset", busy, 0);
        chk("R1", "done in reset", done, 0);
        chk("R1", "rdata in reset", rdata, 0);
        chk("R1", "smp_clk in reset", smp_clk, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        xfer(1'b0, 1'b0, 16'hA5C3, 25'h1B3_5A97);
        xfer(1'b0, 1'b1, 16'h8001, 25'h0F0_F0F1);
        xfer(1'b1, 1'b0, 16'h339B, 25'h1FF_1234);
        smp_div = 8'd0;
        xfer(1'b1, 1'b1, 16'hFF64, 25'h100_8001);

        // R5 and R7: polarity change and start pulses mid-transfer
        @(negedge clk);
        mode_mw = 1'b1; cpol = 1'b1; cmd = 16'h00C6; stream = 25'h0AA_C35F;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        cpol = 1'b0; start = 1'b1; cmd = 16'hFFFF;
        repeat (3) @(negedge clk);
        start = 1'b0;
        chk("R7", "busy through ignored start", busy, 1);
        chk("R5", "sclk polarity latched", sclk, 1'b1 ^ ((m_t - 1) / H % 2 == 1));
        wait_idle();
        chk("R4", "received word after disturbance", rdata, 16'hC35F);
        @(negedge clk);
        chk("R7", "no queued restart", busy, 0);
        chk("R5", "idle level follows cpol", sclk, 0);

        // R7: start held into the first idle cycle
        @(negedge clk);
        mode_mw = 1'b0; cmd = 16'h5A5A; stream = 25'h155_5555;
        start = 1'b1;
        begin
            int guard = 0;
            @(negedge clk);
            while (!done && guard < 5000) begin
                @(negedge clk);
                guard++;
            end
        end
        @(negedge clk);
        chk("R7", "restart from idle cycle", busy, 1);
        start = 1'b0;
        wait_idle();
        chk("R3", "back-to-back word", rdata, 16'hAAAA);

        // R8: sample clock spacing
        smp_div = 8'd5;
        repeat (20) @(negedge clk);
        begin
            logic lv;
            int   gap = 0;
            lv = smp_clk;
            while (smp_clk == lv) @(negedge clk);
            lv = smp_clk;
            while (smp_clk == lv && gap < 100) begin
                @(negedge clk);
                gap++;
            end
            chk("R8", "sample clock half period", gap, 6);
        end
        repeat (10) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R2: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule